// File: doc/BRIEF.md
# Address Translation Controller

This controller sits between a CPU read port and main memory and turns each virtual read request into a physical read. It accepts a request with its virtual address and queries an external translation lookaside buffer with the virtual page number. On a hit it builds the physical address at once and issues a single RAM read. On a miss it reads a page-table entry from memory and checks the valid bit. A valid entry yields the RAM read together with a refill write into the TLB. An invalid entry parks the controller in a fault state until the CPU acknowledges it.

The virtual address is split into a page number and an in-page offset. The offset width is set by `PAGE_BITS` (12 bits, so 4 KiB pages, by default). The physical address is the physical page number with the offset appended unchanged. The page-table entry address is a base input plus the page number scaled by the entry size `PTE_BYTES`. A hit costs one memory access; a miss costs two. Loading a missing page from backing storage is left to software after the fault.

Top module: `mmu_xlate_ctrl`

## Requirements
- R1: After a synchronous reset, `mmu_state` is 0 and `cpu_done`, `cpu_fault`, `tlb_lookup`, `tlb_wr`, `pt_rd` and `ram_rd` are all low.
- R2: `mmu_state` reports the controller state with the encoding 0 idle, 1 read, 2 hit, 3 miss, 4 page fault. While idle with `cpu_rd` low, the controller stays in state 0 and drives no strobe, even if `cpu_ack` is high.
- R3: One cycle after `cpu_rd` is sampled high in idle, the state is 1. In that cycle `tlb_lookup` is high and `tlb_vpn` equals the address bits above `PAGE_BITS`.
- R4: If `tlb_hit` is high in the read state, the next cycle is state 2 with `ram_rd` and `cpu_done` high for exactly one cycle. In that cycle `ram_pa` equals `{tlb_ppn, offset}`, with the offset being the low `PAGE_BITS` bits of the request address. The following cycle is idle.
- R5: If `tlb_hit` is low in the read state, the next cycle is state 3 with a one-cycle `pt_rd` pulse. `pt_addr` equals `pt_base + vpn * PTE_BYTES`, modulo 2^PA_W.
- R6: A page-table entry has its valid bit at position `PA_W-PAGE_BITS` and the physical page number in the bits below it. When `pt_rvalid` arrives with the valid bit set, the next cycle has `ram_rd`, `tlb_wr` and `cpu_done` all high together. In that cycle `ram_pa` is `{entry ppn, offset}`, `tlb_wr_vpn` is the request page number and `tlb_wr_ppn` is the entry page number. The cycle after that is idle.
- R7: While in state 3 and waiting for `pt_rvalid`, `ram_rd`, `cpu_done`, `tlb_wr` and a further `pt_rd` stay low for any length of wait.
- R8: When `pt_rvalid` arrives with the valid bit clear, the next cycle is state 4 with `cpu_fault` high. `ram_rd` and `tlb_wr` stay low. The fault holds until `cpu_ack` is sampled high, and the next cycle is idle with `cpu_fault` low.
- R9: `cpu_rd` is ignored outside the idle state: the captured page number and offset do not change, and no new lookup starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd | input | 1 | CPU read request strobe |
| cpu_va | input | VA_W | CPU virtual address |
| cpu_ack | input | 1 | CPU acknowledge of a page fault |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_fault | output | 1 | Page fault flag, held until acknowledge |
| tlb_lookup | output | 1 | TLB lookup strobe |
| tlb_vpn | output | VA_W-PAGE_BITS | Page number presented to the TLB |
| tlb_hit | input | 1 | TLB hit flag for the lookup |
| tlb_ppn | input | PA_W-PAGE_BITS | Physical page number from the TLB |
| tlb_wr | output | 1 | TLB refill write strobe |
| tlb_wr_vpn | output | VA_W-PAGE_BITS | Refill virtual page number |
| tlb_wr_ppn | output | PA_W-PAGE_BITS | Refill physical page number |
| pt_base | input | PA_W | Page-table base address |
| pt_rd | output | 1 | Page-table entry read strobe |
| pt_addr | output | PA_W | Page-table entry address |
| pt_rvalid | input | 1 | Page-table read data valid |
| pt_rdata | input | PA_W-PAGE_BITS+1 | Page-table entry: valid bit over page number |
| ram_rd | output | 1 | Physical RAM read strobe |
| ram_pa | output | PA_W | Physical address of the RAM read |
| mmu_state | output | 3 | Current controller state code |

## Verification
The TLB refill write and the RAM data read fall in the same cycle when a miss resolves with a valid entry. The bench provokes this with misses whose entries come back after different wait lengths. It judges one sampled cycle: `ram_rd`, `tlb_wr` and `cpu_done` must all be high together, with `ram_pa`, `tlb_wr_vpn` and `tlb_wr_ppn` matching the request and the entry. It also checks that neither strobe appears while the entry is outstanding, and that an invalid entry raises neither.

// File: rtl/mmu_xlate_pkg.sv
package mmu_xlate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_HIT   = 3'd2,
    ST_MISS  = 3'd3,
    ST_FAULT = 3'd4
  } xlate_state_t;

endpackage

// File: rtl/mmu_va_latch.sv
// Captures the request address and derives the page number, offset and
// page-table entry address once, on acceptance.
module mmu_va_latch #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BYTES = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic [VA_W-1:0]           va_in,
  input  logic [PA_W-1:0]           base_in,
  output logic [VA_W-PAGE_BITS-1:0] vpn_q,
  output logic [PAGE_BITS-1:0]      off_q,
  output logic [PA_W-1:0]           pte_addr_q
);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);

  logic [VPN_W-1:0] vpn_in;
  logic [PA_W-1:0]  vpn_scaled;

  assign vpn_in = va_in[VA_W-1:PAGE_BITS];

  generate
    if (PTE_SHIFT == 0) begin : g_byte_entry
      assign vpn_scaled = PA_W'(vpn_in);
    end else begin : g_wide_entry
      assign vpn_scaled = PA_W'(vpn_in) << PTE_SHIFT;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q      <= '0;
      off_q      <= '0;
      pte_addr_q <= '0;
    end else if (capture) begin
      vpn_q      <= vpn_in;
      off_q      <= va_in[PAGE_BITS-1:0];
      pte_addr_q <= base_in + vpn_scaled;
    end
  end

endmodule

// File: rtl/mmu_xlate_fsm.sv
// Five-state sequencer with registered strobes.
module mmu_xlate_fsm
  import mmu_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         cpu_rd,
  input  logic         cpu_ack,
  input  logic         tlb_hit,
  input  logic         pt_rvalid,
  input  logic         pte_valid,
  output xlate_state_t state,
  output logic         capture,
  output logic         load_hit,
  output logic         load_pte,
  output logic         lookup,
  output logic         pt_rd,
  output logic         ram_rd,
  output logic         done,
  output logic         tlb_wr,
  output logic         fault
);
  logic fin;

  assign capture  = (state == ST_IDLE) && cpu_rd;
  assign load_hit = (state == ST_READ) && tlb_hit;
  assign load_pte = (state == ST_MISS) && !fin && pt_rvalid && pte_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      fin    <= 1'b0;
      lookup <= 1'b0;
      pt_rd  <= 1'b0;
      ram_rd <= 1'b0;
      done   <= 1'b0;
      tlb_wr <= 1'b0;
      fault  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cpu_rd) begin
            state  <= ST_READ;
            lookup <= 1'b1;
          end
        end
        ST_READ: begin
          lookup <= 1'b0;
          if (tlb_hit) begin
            state  <= ST_HIT;
            ram_rd <= 1'b1;
            done   <= 1'b1;
          end else begin
            state <= ST_MISS;
            pt_rd <= 1'b1;
          end
        end
        ST_HIT: begin
          ram_rd <= 1'b0;
          done   <= 1'b0;
          state  <= ST_IDLE;
        end
        ST_MISS: begin
          pt_rd <= 1'b0;
          if (fin) begin
            fin    <= 1'b0;
            ram_rd <= 1'b0;
            done   <= 1'b0;
            tlb_wr <= 1'b0;
            state  <= ST_IDLE;
          end else if (pt_rvalid) begin
            if (pte_valid) begin
              fin    <= 1'b1;
              ram_rd <= 1'b1;
              done   <= 1'b1;
              tlb_wr <= 1'b1;
            end else begin
              fault <= 1'b1;
              state <= ST_FAULT;
            end
          end
        end
        ST_FAULT: begin
          if (cpu_ack) begin
            fault <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: begin
          state  <= ST_IDLE;
          fin    <= 1'b0;
          lookup <= 1'b0;
          pt_rd  <= 1'b0;
          ram_rd <= 1'b0;
          done   <= 1'b0;
          tlb_wr <= 1'b0;
          fault  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mmu_pa_reg.sv
// Physical address and refill page registers.
module mmu_pa_reg #(
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_hit,
  input  logic                      load_pte,
  input  logic [PA_W-PAGE_BITS-1:0] tlb_ppn,
  input  logic [PA_W-PAGE_BITS-1:0] pte_ppn,
  input  logic [PAGE_BITS-1:0]      off,
  output logic [PA_W-1:0]           pa_q,
  output logic [PA_W-PAGE_BITS-1:0] refill_ppn_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pa_q         <= '0;
      refill_ppn_q <= '0;
    end else if (load_hit) begin
      pa_q <= {tlb_ppn, off};
    end else if (load_pte) begin
      pa_q         <= {pte_ppn, off};
      refill_ppn_q <= pte_ppn;
    end
  end

endmodule

// File: rtl/mmu_xlate_ctrl.sv
module mmu_xlate_ctrl
  import mmu_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BYTES = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_rd,
  input  logic [VA_W-1:0]  cpu_va,
  input  logic             cpu_ack,
  output logic             cpu_done,
  output logic             cpu_fault,
  output logic             tlb_lookup,
  output logic [VPN_W-1:0] tlb_vpn,
  input  logic             tlb_hit,
  input  logic [PPN_W-1:0] tlb_ppn,
  output logic             tlb_wr,
  output logic [VPN_W-1:0] tlb_wr_vpn,
  output logic [PPN_W-1:0] tlb_wr_ppn,
  input  logic [PA_W-1:0]  pt_base,
  output logic             pt_rd,
  output logic [PA_W-1:0]  pt_addr,
  input  logic             pt_rvalid,
  input  logic [PPN_W:0]   pt_rdata,
  output logic             ram_rd,
  output logic [PA_W-1:0]  ram_pa,
  output logic [2:0]       mmu_state
);
  xlate_state_t           state;
  logic                   capture, load_hit, load_pte;
  logic [VPN_W-1:0]       vpn_q;
  logic [PAGE_BITS-1:0]   off_q;
  logic                   pte_valid;
  logic [PPN_W-1:0]       pte_ppn;

  assign pte_valid = pt_rdata[PPN_W];
  assign pte_ppn   = pt_rdata[PPN_W-1:0];

  mmu_va_latch #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_BYTES(PTE_BYTES)
  ) u_va_latch (
    .clk(clk), .rst(rst), .capture(capture), .va_in(cpu_va),
    .base_in(pt_base), .vpn_q(vpn_q), .off_q(off_q), .pte_addr_q(pt_addr)
  );

  mmu_xlate_fsm u_fsm (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_ack(cpu_ack),
    .tlb_hit(tlb_hit), .pt_rvalid(pt_rvalid), .pte_valid(pte_valid),
    .state(state), .capture(capture), .load_hit(load_hit),
    .load_pte(load_pte), .lookup(tlb_lookup), .pt_rd(pt_rd),
    .ram_rd(ram_rd), .done(cpu_done), .tlb_wr(tlb_wr), .fault(cpu_fault)
  );

  mmu_pa_reg #(
    .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
  ) u_pa_reg (
    .clk(clk), .rst(rst), .load_hit(load_hit), .load_pte(load_pte),
    .tlb_ppn(tlb_ppn), .pte_ppn(pte_ppn), .off(off_q),
    .pa_q(ram_pa), .refill_ppn_q(tlb_wr_ppn)
  );

  assign tlb_vpn    = vpn_q;
  assign tlb_wr_vpn = vpn_q;
  assign mmu_state  = state;

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] st,
  input logic       lookup,
  input logic       pt_rd,
  input logic       ram_rd,
  input logic       done,
  input logic       tlb_wr,
  input logic       fault,
  input logic       ack
);
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    st <= 3'd4);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    st == 3'd0 |-> !ram_rd && !pt_rd && !tlb_wr && !fault && !done);  // R2
  AST_LOOKUP_IN_READ: assert property (@(posedge clk) disable iff (rst)
    lookup |-> st == 3'd1);  // R3
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    st == 3'd2 |=> st == 3'd0);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R4
  AST_PT_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    pt_rd |=> !pt_rd);  // R5
  AST_REFILL_WITH_RAM: assert property (@(posedge clk) disable iff (rst)
    tlb_wr |-> ram_rd && done && st == 3'd3);  // R6
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    fault && !ack |=> fault);  // R8
  AST_FAULT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    fault |-> !ram_rd && !tlb_wr && st == 3'd4);  // R8
endmodule

bind mmu_xlate_ctrl mmu_xlate_chk u_chk (
  .clk(clk), .rst(rst), .st(mmu_state), .lookup(tlb_lookup), .pt_rd(pt_rd),
  .ram_rd(ram_rd), .done(cpu_done), .tlb_wr(tlb_wr), .fault(cpu_fault),
  .ack(cpu_ack)
);

// File: tb/mmu_xlate_ctrl_bench.sv
`timescale 1ns/1ps
module mmu_xlate_ctrl_bench;
  localparam int VA_W = 32, PA_W = 30, PB = 12, PTEB = 4;
  localparam int VPN_W = VA_W - PB, PPN_W = PA_W - PB;
  localparam logic [PA_W-1:0] BASE = 30'h0200_0000;

  // vector table: address, tlb hit, tlb ppn, pte valid, pte ppn, entry wait
  localparam int NV = 6;
  localparam logic [31:0]      V_VA  [NV] = '{32'h0000_1ABC, 32'hFFFF_F000,
    32'h1234_5678, 32'h0000_0FFF, 32'hDEAD_BEEF, 32'h8000_0123};
  localparam logic             V_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic [PPN_W-1:0] V_TPPN[NV] = '{18'h00055, 18'h3FFFF, 18'h01111,
    18'h02222, 18'h03333, 18'h20000};
  localparam logic             V_PV  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [PPN_W-1:0] V_PPPN[NV] = '{18'h0, 18'h0, 18'h2AAAA,
    18'h00001, 18'h1F00F, 18'h0};
  localparam int               V_LAT [NV] = '{0, 0, 0, 3, 1, 0};

  logic clk = 1'b0, rst = 1'b1;
  logic cpu_rd = 1'b0, cpu_ack = 1'b0, tlb_hit = 1'b0, pt_rvalid = 1'b0;
  logic [VA_W-1:0] cpu_va = '0;
  logic [PPN_W-1:0] tlb_ppn = '0;
  logic [PPN_W:0] pt_rdata = '0;
  logic cpu_done, cpu_fault, tlb_lookup, tlb_wr, pt_rd, ram_rd;
  logic [VPN_W-1:0] tlb_vpn, tlb_wr_vpn;
  logic [PPN_W-1:0] tlb_wr_ppn;
  logic [PA_W-1:0] pt_addr, ram_pa;
  logic [2:0] mmu_state;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mmu_xlate_ctrl u_mmu_xlate_ctrl (
    .clk(clk), .rst(rst), .cpu_rd(cpu_rd), .cpu_va(cpu_va), .cpu_ack(cpu_ack),
    .cpu_done(cpu_done), .cpu_fault(cpu_fault), .tlb_lookup(tlb_lookup),
    .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_wr(tlb_wr),
    .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn), .pt_base(BASE),
    .pt_rd(pt_rd), .pt_addr(pt_addr), .pt_rvalid(pt_rvalid),
    .pt_rdata(pt_rdata), .ram_rd(ram_rd), .ram_pa(ram_pa),
    .mmu_state(mmu_state)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [PA_W-1:0] exp_pt(input logic [VA_W-1:0] va);
    return BASE + (PA_W'(va[VA_W-1:PB]) << $clog2(PTEB));
  endfunction

  task automatic strobes_low(input string req);
    chk(req, "strobes", {ram_rd, cpu_done, tlb_wr, pt_rd, cpu_fault}, 5'b0);
  endtask

  task automatic run_vec(input int i);
    logic [VA_W-1:0] va = V_VA[i];
    tlb_hit = V_HIT[i];
    tlb_ppn = V_TPPN[i];
    cpu_va = va; cpu_rd = 1'b1;
    step();
    cpu_rd = 1'b0;
    chk("R3", "state", mmu_state, 3'd1);
    chk("R3", "lookup", tlb_lookup, 1'b1);
    chk("R3", "vpn", tlb_vpn, va[VA_W-1:PB]);
    step();
    if (V_HIT[i]) begin
      chk("R4", "state", mmu_state, 3'd2);
      chk("R4", "ram_rd/done/pt_rd", {ram_rd, cpu_done, pt_rd}, 3'b110);
      chk("R4", "pa", ram_pa, {V_TPPN[i], va[PB-1:0]});
      step();
      chk("R4", "back to idle", mmu_state, 3'd0);
      strobes_low("R4");
    end else begin
      chk("R5", "state", mmu_state, 3'd3);
      chk("R5", "pt_rd", {pt_rd, ram_rd}, 2'b10);
      chk("R5", "pt_addr", pt_addr, exp_pt(va));
      for (int w = 0; w < V_LAT[i]; w++) begin
        step();
        chk("R7", "wait quiet", {ram_rd, cpu_done, tlb_wr, pt_rd}, 4'b0);
        chk("R7", "wait state", mmu_state, 3'd3);
      end
      pt_rvalid = 1'b1; pt_rdata = {V_PV[i], V_PPPN[i]};
      step();
      pt_rvalid = 1'b0;
      if (V_PV[i]) begin
        chk("R6", "ram_rd/tlb_wr/done together", {ram_rd, tlb_wr, cpu_done}, 3'b111);
        chk("R6", "pa", ram_pa, {V_PPPN[i], va[PB-1:0]});
        chk("R6", "refill vpn", tlb_wr_vpn, va[VA_W-1:PB]);
        chk("R6", "refill ppn", tlb_wr_ppn, V_PPPN[i]);
        step();
        chk("R6", "back to idle", mmu_state, 3'd0);
        strobes_low("R6");
      end else begin
        chk("R8", "state", mmu_state, 3'd4);
        chk("R8", "fault/ram_rd/tlb_wr", {cpu_fault, ram_rd, tlb_wr}, 3'b100);
        for (int h = 0; h < 3; h++) begin
          step();
          chk("R8", "fault held", {cpu_fault, mmu_state}, {1'b1, 3'd4});
        end
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        chk("R8", "idle after ack", {cpu_fault, mmu_state}, {1'b0, 3'd0});
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    // R1 reset state
    chk("R1", "state", mmu_state, 3'd0);
    strobes_low("R1");
    chk("R1", "lookup", tlb_lookup, 1'b0);
    // R2 idle ignores acknowledge
    cpu_ack = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R2", "idle state", mmu_state, 3'd0);
      strobes_low("R2");
    end
    cpu_ack = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(i);

    // R9: request during miss wait is ignored
    tlb_hit = 1'b0;
    cpu_va = 32'h0ABC_D123; cpu_rd = 1'b1;
    step();
    cpu_va = 32'h7777_7777;
    step();
    step();
    cpu_rd = 1'b0;
    chk("R9", "vpn kept", tlb_vpn, 20'h0ABCD);
    chk("R9", "still miss", {mmu_state, tlb_lookup}, {3'd3, 1'b0});
    pt_rvalid = 1'b1; pt_rdata = {1'b1, 18'h12345};
    step();
    pt_rvalid = 1'b0;
    chk("R9", "offset kept", ram_pa, {18'h12345, 12'h123});
    step();

    // R9: request in hit cycle does not start a lookup
    tlb_hit = 1'b1; tlb_ppn = 18'h00ABC;
    cpu_va = 32'h0000_5001; cpu_rd = 1'b1;
    step();
    cpu_rd = 1'b0;
    step();
    chk("R4", "hit", mmu_state, 3'd2);
    cpu_va = 32'h0009_9000; cpu_rd = 1'b1;
    step();
    cpu_rd = 1'b0;
    chk("R9", "no lookup after hit", {mmu_state, tlb_lookup}, {3'd0, 1'b0});
    chk("R9", "vpn kept", tlb_vpn, 20'h00005);

    // R1: reset while faulted
    tlb_hit = 1'b0;
    cpu_va = 32'h0000_3000; cpu_rd = 1'b1;
    step();
    cpu_rd = 1'b0;
    step();
    pt_rvalid = 1'b1; pt_rdata = '0;
    step();
    pt_rvalid = 1'b0;
    chk("R8", "fault", cpu_fault, 1'b1);
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R1", "reset clears fault", {cpu_fault, mmu_state}, {1'b0, 3'd0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule